// File: doc/BRIEF.md
# Paged NIC Host Register Bank

This block is the byte-wide host register file of a small Ethernet controller core. A host reaches it through a 5-bit address, separate read and write strobes, and 8-bit data buses. The two top bits of the command byte choose one of four register pages. Most offsets on page 0 have one meaning when read and another when written. A write stores a configuration value that drives the core. A read returns a live status or counter value that the core supplies.

The block also holds an interrupt status register and its mask. Core event pulses set status bits. The host clears a bit by writing a 1 to it, and the interrupt line is raised whenever an unmasked status bit is set. A dedicated reset port at the top of the address space controls the core reset line: reading the port puts the core into reset, and writing any value to it releases the reset. The command register also carries stop and start requests, and the highest status bit reports whether the core is stopped.

Top module: `nic_regbank`

## Requirements
- R1: After reset, the command register reads 0x21, the interrupt status reads 0x80, `core_reset`, `irq` and `core_run` are low, and every configuration output is zero.
- R2: Offset 0 is the command register on every page. Its bits 7:6 select the page (00 is page 0), it reads back the byte last written, and bits 5:3 appear on `rdma_mode`.
- R3: Writing the command register with bit 0 set stops the core: `core_run` goes low and status bit 7 is set. Writing it with bit 1 set and bit 0 clear starts the core and clears status bit 7. Stop takes priority when both bits are set.
- R4: Page 0 writes set these outputs: offset 1 sets `ring_start`, offset 2 sets `ring_stop`, offset 4 sets `tx_page`, offsets 5 and 6 set the low and high bytes of `tx_count`, offsets 8 and 9 set the low and high bytes of `rmt_start`, offsets 0xA and 0xB set the low and high bytes of `rmt_count`, offset 0xC sets `rx_cfg`, offset 0xD sets `tx_cfg`, offset 0xE sets `data_cfg`, and offset 0xF sets the interrupt mask.
- R5: Page 0 reads return these values: offsets 1 and 2 return the low and high bytes of `local_dma_addr`, offset 4 returns `tx_status`, offset 5 returns `coll_count`, offsets 8 and 9 return the low and high bytes of `remote_dma_addr`, offset 0xC returns `rx_status`, and offsets 0xD, 0xE and 0xF return `err_align`, `err_crc` and `err_missed`.
- R6: Offset 7 on page 0 is the interrupt status register. Pulsing `ev_pulse[i]` (i from 0 to 6) sets bit i. Writing a 1 to a bit clears it and writing a 0 leaves it unchanged. Bit 7 always reflects the stop state, and writes to bit 7 are ignored.
- R7: If an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R8: `irq` is high exactly when some status bit is set and its mask bit is also set.
- R9: A read of offset 0x1F drives `core_reset` high, a write of any value to offset 0x1F drives it low, and the read data of that offset is 0.
- R10: On pages 1 to 3, reads of offsets 1 to 0x0F return 0, and writes to those offsets change no configuration output.
- R11: Read data appears on `host_rdata` on the cycle after the read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 5 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_rdata | output | 8 | Registered read data |
| ev_pulse | input | 7 | Core event pulses for status bits 0 to 6 |
| local_dma_addr | input | 16 | Current local DMA address |
| remote_dma_addr | input | 16 | Current remote DMA address |
| tx_status | input | 8 | Transmit status |
| rx_status | input | 8 | Receive status |
| coll_count | input | 8 | Collision count |
| err_align | input | 8 | Alignment error counter |
| err_crc | input | 8 | CRC error counter |
| err_missed | input | 8 | Missed frame counter |
| ring_start | output | 8 | Receive ring first page |
| ring_stop | output | 8 | Receive ring last page plus one |
| tx_page | output | 8 | Transmit start page |
| tx_count | output | 16 | Transmit byte count |
| rmt_start | output | 16 | Remote DMA start address |
| rmt_count | output | 16 | Remote DMA byte count |
| rx_cfg | output | 8 | Receive configuration |
| tx_cfg | output | 8 | Transmit configuration |
| data_cfg | output | 8 | Data configuration |
| rdma_mode | output | 3 | Remote DMA command bits 5:3 |
| core_run | output | 1 | High while the core is started |
| core_reset | output | 1 | Core reset driven from the reset port |
| irq | output | 1 | Interrupt request |

## Verification
The split between read and write meanings is tested by writing distinct patterns to every page-0 offset and driving different values on every status input. A read that returned the stored byte instead of the status byte, or the reverse, would then show a mismatch. Status bits are set singly and in pairs and cleared with one-hot, zero and bit-7 masks, which separates a correct write-1-to-clear from a plain write or a clear-all. A simultaneous event and clear on the same bit shows which of the two wins. The mask is moved between set and unset bits to catch an irq that ignores the mask or the status. Finally, the same offsets are read and written with page 1 selected, to catch page decoding that falls through to page 0.

// File: rtl/nic_regbank_pkg.sv
package nic_regbank_pkg;

   localparam int CFG_NREG = 13;

   localparam int CFG_RING_START = 0;
   localparam int CFG_RING_STOP  = 1;
   localparam int CFG_TX_PAGE    = 2;
   localparam int CFG_TXCNT_LO   = 3;
   localparam int CFG_TXCNT_HI   = 4;
   localparam int CFG_RSA_LO     = 5;
   localparam int CFG_RSA_HI     = 6;
   localparam int CFG_RBC_LO     = 7;
   localparam int CFG_RBC_HI     = 8;
   localparam int CFG_RXCFG      = 9;
   localparam int CFG_TXCFG      = 10;
   localparam int CFG_DATACFG    = 11;
   localparam int CFG_MASK       = 12;

   localparam logic [3:0] OFS_CMD   = 4'h0;
   localparam logic [3:0] OFS_ISR   = 4'h7;

   // Page-0 offset that each configuration register index is written at
   function automatic logic [3:0] cfg_ofs(input int k);
      case (k)
         0:       return 4'h1;
         1:       return 4'h2;
         2:       return 4'h4;
         3:       return 4'h5;
         4:       return 4'h6;
         5:       return 4'h8;
         6:       return 4'h9;
         7:       return 4'hA;
         8:       return 4'hB;
         9:       return 4'hC;
         10:      return 4'hD;
         11:      return 4'hE;
         default: return 4'hF;
      endcase
   endfunction

endpackage

// File: rtl/nic_cmd_unit.sv
module nic_cmd_unit #(
   parameter int DW = 8,
   parameter logic [DW-1:0] CMD_RST = 8'h21
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_we,
   input  logic [DW-1:0] wdata,
   input  logic          rstport_rd,
   input  logic          rstport_wr,
   output logic [DW-1:0] cmd_q,
   output logic          stopped,
   output logic          core_reset
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= CMD_RST;
         stopped <= 1'b1;
      end else if (cmd_we) begin
         cmd_q <= wdata;
         if (wdata[0])
            stopped <= 1'b1;
         else if (wdata[1])
            stopped <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         core_reset <= 1'b0;
      else if (rstport_wr)
         core_reset <= 1'b0;
      else if (rstport_rd)
         core_reset <= 1'b1;
   end

   AST_STOP_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && wdata[0]) |=> stopped); // R3
   AST_START_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && wdata[1] && !wdata[0]) |=> !stopped); // R3
   AST_RSTPORT_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
      (rstport_rd && !rstport_wr) |=> core_reset); // R9
   AST_RSTPORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      rstport_wr |=> !core_reset); // R9

endmodule

// File: rtl/nic_isr_unit.sv
module nic_isr_unit #(
   parameter int NBIT = 8,
   parameter int NEVT = NBIT - 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NEVT-1:0] ev,
   input  logic            clr_we,
   input  logic [NEVT-1:0] clr_bits,
   input  logic            stopped,
   input  logic [NBIT-1:0] mask,
   output logic [NBIT-1:0] isr,
   output logic            irq
);

   if (NEVT != NBIT - 1) begin : g_bad_cfg
      $error("nic_isr_unit: NEVT must leave exactly one status bit for the stop state");
   end

   for (genvar i = 0; i < NEVT; i++) begin : g_cell
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (ev[i])
            bit_q <= 1'b1;
         else if (clr_we && clr_bits[i])
            bit_q <= 1'b0;
      end
      assign isr[i] = bit_q;

      AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         ev[i] |=> isr[i]); // R7
      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we && clr_bits[i] && !ev[i]) |=> !isr[i]); // R6
   end

   assign isr[NBIT-1] = stopped;
   assign irq = |(isr & mask);

endmodule

// File: rtl/nic_cfg_bank.sv
module nic_cfg_bank
   import nic_regbank_pkg::*;
#(
   parameter int DW   = 8,
   parameter int NREG = CFG_NREG
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [3:0]               ofs,
   input  logic [DW-1:0]            wdata,
   output logic [NREG-1:0][DW-1:0]  cfg_q
);

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      localparam logic [3:0] MY_OFS = cfg_ofs(k);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg_q[k] <= '0;
         else if (we && ofs == MY_OFS)
            cfg_q[k] <= wdata;
      end
   end

endmodule

// File: rtl/nic_regbank.sv
module nic_regbank
   import nic_regbank_pkg::*;
#(
   parameter int AW = 5,
   parameter int DW = 8,
   parameter int PW = 2,
   parameter int NEVT = 7,
   parameter logic [AW-1:0] RST_PORT = 5'h1F
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   host_addr,
   input  logic [DW-1:0]   host_wdata,
   input  logic            host_wr,
   input  logic            host_rd,
   output logic [DW-1:0]   host_rdata,
   input  logic [NEVT-1:0] ev_pulse,
   input  logic [2*DW-1:0] local_dma_addr,
   input  logic [2*DW-1:0] remote_dma_addr,
   input  logic [DW-1:0]   tx_status,
   input  logic [DW-1:0]   rx_status,
   input  logic [DW-1:0]   coll_count,
   input  logic [DW-1:0]   err_align,
   input  logic [DW-1:0]   err_crc,
   input  logic [DW-1:0]   err_missed,
   output logic [DW-1:0]   ring_start,
   output logic [DW-1:0]   ring_stop,
   output logic [DW-1:0]   tx_page,
   output logic [2*DW-1:0] tx_count,
   output logic [2*DW-1:0] rmt_start,
   output logic [2*DW-1:0] rmt_count,
   output logic [DW-1:0]   rx_cfg,
   output logic [DW-1:0]   tx_cfg,
   output logic [DW-1:0]   data_cfg,
   output logic [2:0]      rdma_mode,
   output logic            core_run,
   output logic            core_reset,
   output logic            irq
);

   localparam int NBIT = NEVT + 1;

   if (DW != 8 || AW != 5 || PW != 2 || NBIT != DW) begin : g_bad_cfg
      $error("nic_regbank: widths must be 8-bit data, 5-bit address, 2-bit page");
   end

   logic [3:0]                 ofs;
   logic                       lo_space;
   logic [DW-1:0]              cmd_q;
   logic [PW-1:0]              page;
   logic                       stopped;
   logic                       wr_p0;
   logic [DW-1:0]              isr;
   logic [CFG_NREG-1:0][DW-1:0] cfg_q;
   logic [DW-1:0]              rd_mux;
   logic [DW-1:0]              rdata_q;

   assign ofs      = host_addr[3:0];
   assign lo_space = !host_addr[AW-1];
   assign page     = cmd_q[DW-1 -: PW];
   assign wr_p0    = host_wr && lo_space && page == '0;

   nic_cmd_unit #(.DW(DW)) i_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_we     (host_wr && lo_space && ofs == OFS_CMD),
      .wdata      (host_wdata),
      .rstport_rd (host_rd && host_addr == RST_PORT),
      .rstport_wr (host_wr && host_addr == RST_PORT),
      .cmd_q      (cmd_q),
      .stopped    (stopped),
      .core_reset (core_reset)
   );

   nic_cfg_bank #(.DW(DW), .NREG(CFG_NREG)) i_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_p0),
      .ofs   (ofs),
      .wdata (host_wdata),
      .cfg_q (cfg_q)
   );

   nic_isr_unit #(.NBIT(NBIT), .NEVT(NEVT)) i_isr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev_pulse),
      .clr_we   (wr_p0 && ofs == OFS_ISR),
      .clr_bits (host_wdata[NEVT-1:0]),
      .stopped  (stopped),
      .mask     (cfg_q[CFG_MASK]),
      .isr      (isr),
      .irq      (irq)
   );

   always_comb begin
      rd_mux = '0;
      if (lo_space) begin
         if (ofs == OFS_CMD)
            rd_mux = cmd_q;
         else if (page == '0) begin
            case (ofs)
               4'h1:    rd_mux = local_dma_addr[DW-1:0];
               4'h2:    rd_mux = local_dma_addr[2*DW-1:DW];
               4'h4:    rd_mux = tx_status;
               4'h5:    rd_mux = coll_count;
               4'h7:    rd_mux = isr;
               4'h8:    rd_mux = remote_dma_addr[DW-1:0];
               4'h9:    rd_mux = remote_dma_addr[2*DW-1:DW];
               4'hC:    rd_mux = rx_status;
               4'hD:    rd_mux = err_align;
               4'hE:    rd_mux = err_crc;
               4'hF:    rd_mux = err_missed;
               default: rd_mux = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (host_rd)
         rdata_q <= rd_mux;
   end
   assign host_rdata = rdata_q;

   assign ring_start = cfg_q[CFG_RING_START];
   assign ring_stop  = cfg_q[CFG_RING_STOP];
   assign tx_page    = cfg_q[CFG_TX_PAGE];
   assign tx_count   = {cfg_q[CFG_TXCNT_HI], cfg_q[CFG_TXCNT_LO]};
   assign rmt_start  = {cfg_q[CFG_RSA_HI], cfg_q[CFG_RSA_LO]};
   assign rmt_count  = {cfg_q[CFG_RBC_HI], cfg_q[CFG_RBC_LO]};
   assign rx_cfg     = cfg_q[CFG_RXCFG];
   assign tx_cfg     = cfg_q[CFG_TXCFG];
   assign data_cfg   = cfg_q[CFG_DATACFG];
   assign rdma_mode  = cmd_q[5:3];
   assign core_run   = !stopped;

   AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_p0 && ofs == 4'hF && host_wdata == '0) |=> !irq); // R8
   AST_HIPAGE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && lo_space && ofs != OFS_CMD && page != '0) |=> host_rdata == '0); // R10
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd |=> $stable(host_rdata)); // R11
   AST_RSTPORT_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == RST_PORT) |=> host_rdata == '0); // R9

endmodule

// File: tb/test_nic_regbank.sv
module test_nic_regbank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [7:0]  host_rdata;
   logic [6:0]  ev_pulse = '0;
   logic [15:0] local_dma_addr = 16'hA1B2;
   logic [15:0] remote_dma_addr = 16'hC3D4;
   logic [7:0]  tx_status = 8'h5A;
   logic [7:0]  rx_status = 8'h21;
   logic [7:0]  coll_count = 8'h07;
   logic [7:0]  err_align = 8'h11;
   logic [7:0]  err_crc = 8'h22;
   logic [7:0]  err_missed = 8'h33;
   logic [7:0]  ring_start, ring_stop, tx_page, rx_cfg, tx_cfg, data_cfg;
   logic [15:0] tx_count, rmt_start, rmt_count;
   logic [2:0]  rdma_mode;
   logic        core_run, core_reset, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   nic_regbank i_nic_regbank (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
      .ev_pulse(ev_pulse), .local_dma_addr(local_dma_addr),
      .remote_dma_addr(remote_dma_addr), .tx_status(tx_status),
      .rx_status(rx_status), .coll_count(coll_count), .err_align(err_align),
      .err_crc(err_crc), .err_missed(err_missed), .ring_start(ring_start),
      .ring_stop(ring_stop), .tx_page(tx_page), .tx_count(tx_count),
      .rmt_start(rmt_start), .rmt_count(rmt_count), .rx_cfg(rx_cfg),
      .tx_cfg(tx_cfg), .data_cfg(data_cfg), .rdma_mode(rdma_mode),
      .core_run(core_run), .core_reset(core_reset), .irq(irq)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic host_write(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [4:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic pulse(input logic [6:0] v);
      @(negedge clk);
      ev_pulse = v;
      @(negedge clk);
      ev_pulse = '0;
   endtask

   // Monitor: every read strobe seen at an edge yields one result one half cycle later
   initial begin
      forever begin
         @(posedge clk);
         if (host_rd) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R11: unexpected read result 0x%0h expected none", host_rdata);
            end else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(t, {8'h00, host_rdata}, {8'h00, e});
            end
         end
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 core_reset", {15'h0, core_reset}, 16'h0);
      chk("R1 irq", {15'h0, irq}, 16'h0);
      chk("R1 core_run", {15'h0, core_run}, 16'h0);
      chk("R1 ring_start", {8'h0, ring_start}, 16'h0);
      chk("R1 tx_count", tx_count, 16'h0);
      host_read(5'h00, 8'h21, "R1 cmd");
      host_read(5'h07, 8'h80, "R1 isr");

      // R2/R3 start the core
      host_write(5'h00, 8'h22);
      chk("R3 core_run after start", {15'h0, core_run}, 16'h1);
      chk("R2 rdma_mode", {13'h0, rdma_mode}, 16'h4);
      host_read(5'h00, 8'h22, "R2 cmd readback");
      host_read(5'h07, 8'h00, "R3 isr resetting cleared");

      // R4 page-0 configuration writes
      host_write(5'h01, 8'h46); host_write(5'h02, 8'h80);
      host_write(5'h04, 8'h40); host_write(5'h05, 8'h3C);
      host_write(5'h06, 8'h01); host_write(5'h08, 8'h55);
      host_write(5'h09, 8'h12); host_write(5'h0A, 8'h34);
      host_write(5'h0B, 8'h02); host_write(5'h0C, 8'h04);
      host_write(5'h0D, 8'h02); host_write(5'h0E, 8'h48);
      host_write(5'h0F, 8'h00);
      chk("R4 ring_start", {8'h0, ring_start}, 16'h46);
      chk("R4 ring_stop", {8'h0, ring_stop}, 16'h80);
      chk("R4 tx_page", {8'h0, tx_page}, 16'h40);
      chk("R4 tx_count", tx_count, 16'h013C);
      chk("R4 rmt_start", rmt_start, 16'h1255);
      chk("R4 rmt_count", rmt_count, 16'h0234);
      chk("R4 rx_cfg", {8'h0, rx_cfg}, 16'h04);
      chk("R4 tx_cfg", {8'h0, tx_cfg}, 16'h02);
      chk("R4 data_cfg", {8'h0, data_cfg}, 16'h48);

      // R5 page-0 status reads
      host_read(5'h01, 8'hB2, "R5 local lo");
      host_read(5'h02, 8'hA1, "R5 local hi");
      host_read(5'h04, 8'h5A, "R5 tx_status");
      host_read(5'h05, 8'h07, "R5 coll_count");
      host_read(5'h08, 8'hD4, "R5 remote lo");
      host_read(5'h09, 8'hC3, "R5 remote hi");
      host_read(5'h0C, 8'h21, "R5 rx_status");
      host_read(5'h0D, 8'h11, "R5 err_align");
      host_read(5'h0E, 8'h22, "R5 err_crc");
      host_read(5'h0F, 8'h33, "R5 err_missed");

      // R11 read data holds without a read strobe
      host_read(5'h04, 8'h5A, "R11 before hold");
      tx_status = 8'h99;
      repeat (3) @(negedge clk);
      chk("R11 rdata held", {8'h0, host_rdata}, 16'h5A);

      // R6 interrupt status set and write-1-to-clear
      pulse(7'h01);
      host_read(5'h07, 8'h01, "R6 single event");
      pulse(7'h12);
      host_read(5'h07, 8'h13, "R6 two events");
      host_write(5'h07, 8'h02);
      host_read(5'h07, 8'h11, "R6 one-hot clear");
      host_write(5'h07, 8'h00);
      host_read(5'h07, 8'h11, "R6 zero write keeps");
      host_write(5'h07, 8'h80);
      host_read(5'h07, 8'h11, "R6 bit7 write ignored");

      // R8 interrupt masking
      chk("R8 irq mask zero", {15'h0, irq}, 16'h0);
      host_write(5'h0F, 8'h10);
      chk("R8 irq unmasked", {15'h0, irq}, 16'h1);
      host_write(5'h0F, 8'h02);
      chk("R8 irq mask on clear bit", {15'h0, irq}, 16'h0);
      host_write(5'h0F, 8'h01);
      chk("R8 irq bit0", {15'h0, irq}, 16'h1);
      host_write(5'h07, 8'h11);
      chk("R8 irq after clear", {15'h0, irq}, 16'h0);
      host_read(5'h07, 8'h00, "R6 all cleared");

      // R7 set wins over clear in the same cycle
      @(negedge clk);
      host_addr = 5'h07; host_wdata = 8'h04; host_wr = 1'b1; ev_pulse = 7'h04;
      @(negedge clk);
      host_wr = 1'b0; ev_pulse = '0;
      host_read(5'h07, 8'h04, "R7 set wins");
      host_write(5'h07, 8'h04);
      host_read(5'h07, 8'h00, "R7 later clear");

      // R3 stop, priority of stop over start
      host_write(5'h00, 8'h21);
      chk("R3 core_run after stop", {15'h0, core_run}, 16'h0);
      host_read(5'h07, 8'h80, "R3 resetting set");
      host_write(5'h0F, 8'h80);
      chk("R8 irq from resetting bit", {15'h0, irq}, 16'h1);
      host_write(5'h0F, 8'h00);
      host_write(5'h00, 8'h03);
      chk("R3 stop priority", {15'h0, core_run}, 16'h0);
      host_write(5'h00, 8'h22);
      chk("R3 restart", {15'h0, core_run}, 16'h1);

      // R9 reset port
      host_read(5'h1F, 8'h00, "R9 reset port data");
      chk("R9 reset asserted", {15'h0, core_reset}, 16'h1);
      host_write(5'h1F, 8'h5C);
      chk("R9 reset released", {15'h0, core_reset}, 16'h0);

      // R10 upper pages
      host_write(5'h00, 8'h62);
      host_read(5'h00, 8'h62, "R2 page1 cmd");
      host_read(5'h01, 8'h00, "R10 page1 off1");
      host_read(5'h0C, 8'h00, "R10 page1 offC");
      host_read(5'h07, 8'h00, "R10 page1 off7");
      host_write(5'h01, 8'hEE);
      host_write(5'h0D, 8'hEE);
      host_write(5'h00, 8'h22);
      chk("R10 ring_start kept", {8'h0, ring_start}, 16'h46);
      chk("R10 tx_cfg kept", {8'h0, tx_cfg}, 16'h02);

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL R11: actual %0d pending reads expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule